// File: doc/BRIEF.md
# Rotating Element Selector with Mismatch Correction

This block sits between a 5-level quantizer and a 4-element unit DAC. Each cycle it converts the quantizer code into a count of active elements. It turns that count into a contiguous run of element enables that starts at a rotation pointer and wraps around the ring of four elements.

The pointer has three sources, chosen by a mode input:
- **Averaging mode:** the pointer advances by the number of elements used, so successive samples cycle through all elements evenly.
- **Calibration mode:** the pointer follows a 2-bit external input. This lets each element in turn be placed first for a whole conversion.
- **Hold mode:** the pointer is fixed at zero, which switches averaging off.

Alongside the enables, the block produces a corrected output word. This word is the level scaled into a signed fixed-point format, minus the stored error terms of the elements enabled that cycle. The four error terms sit in a small table. Software loads the table through an address/data/write-enable port. Measuring the error terms is outside this block.

Top module: `dac_elem_rotator`

## Requirements
- R1: A synchronous active-high reset clears the averaging pointer, every table entry and both outputs to zero.
- R2: The number of enabled elements equals the level code for codes 0 to 4; codes 5 to 7 are treated as 4.
- R3: The enabled elements form one contiguous run around the ring. The run starts at the selected pointer and continues upward, wrapping from element 3 to element 0. Bit k of `elem_en_o` drives element k.
- R4: In averaging mode (`mode_i` = 2'b01), the pointer is the averaging pointer. After each averaging-mode sample it advances modulo 4 by the number of elements used, so the first sample after reset starts at element 0.
- R5: In calibration mode (`mode_i` = 2'b10), the pointer equals `ext_ptr_i` in the same sample. The averaging pointer keeps its value and resumes from it when averaging mode returns.
- R6: In hold mode (`mode_i` = 2'b00 or 2'b11), the pointer is 0 and the averaging pointer keeps its value.
- R7: `corr_o` equals the effective level times 2^FRAC, minus the sum of the table entries of the elements enabled in that sample. It is a two's-complement word CORR_W+3 bits wide, and each entry is a two's-complement CORR_W-bit value.
- R8: With `tbl_we_i` high, `tbl_data_i` is written to entry `tbl_addr_i` at the clock edge. A sample taken at that same edge still uses the old entry; later samples use the new one.
- R9: Both outputs are registered: they reflect the inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| level_i | input | 3 | Quantizer level code |
| mode_i | input | 2 | Pointer source: 00/11 hold, 01 averaging, 10 calibration |
| ext_ptr_i | input | 2 | External pointer used in calibration mode |
| tbl_we_i | input | 1 | Correction table write enable |
| tbl_addr_i | input | 2 | Correction table entry index |
| tbl_data_i | input | CORR_W | Signed error term to write |
| elem_en_o | output | 4 | Unit element enables |
| corr_o | output | CORR_W+3 | Signed corrected output word |

## Verification
Several stimulus patterns are used, and each separates a different class of fault:
- **Hold mode, all eight codes:** shows the thermometer count and the saturation of codes above 4 with no rotation in play.
- **Calibration, every pointer against every level:** shows each wrap-around case of the rotator, independent of any state.
- **Long random averaging runs:** expose errors in the pointer update, such as a wrong modulus or advancing by the raw code.
- **Random mode switches with table writes in the same cycle:** show that the averaging pointer is retained across other modes, and that the write-versus-read ordering of the correction table holds.

// File: rtl/dac_elem_rotator.sv
module dac_elem_rotator #(
  parameter int CORR_W = 8,
  parameter int FRAC   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0]               level_i,
  input  logic [1:0]               mode_i,
  input  logic [1:0]               ext_ptr_i,
  input  logic                     tbl_we_i,
  input  logic [1:0]               tbl_addr_i,
  input  logic [CORR_W-1:0]        tbl_data_i,
  output logic [3:0]               elem_en_o,
  output logic signed [CORR_W+2:0] corr_o
);
  localparam int N_EL  = 4;
  localparam int OUT_W = CORR_W + 3;
  localparam logic [1:0] M_AVG = 2'b01;
  localparam logic [1:0] M_CAL = 2'b10;

  logic [1:0]               avg_ptr, sel_ptr;
  logic [2:0]               lvl;
  logic [N_EL-1:0]          en_nxt;
  logic signed [CORR_W-1:0] tbl [N_EL];
  logic signed [OUT_W-1:0]  err_sum, scaled;

  assign lvl = (level_i > 3'd4) ? 3'd4 : level_i;

  always_comb begin
    case (mode_i)
      M_AVG:   sel_ptr = avg_ptr;
      M_CAL:   sel_ptr = ext_ptr_i;
      default: sel_ptr = 2'd0;
    endcase
  end

  for (genvar i = 0; i < N_EL; i++) begin : g_el
    logic [1:0] off;
    assign off       = 2'(i) - sel_ptr;
    assign en_nxt[i] = {1'b0, off} < lvl;
  end

  always_comb begin
    err_sum = '0;
    for (int i = 0; i < N_EL; i++)
      if (en_nxt[i]) err_sum = err_sum + OUT_W'(tbl[i]);
  end

  assign scaled = signed'({{(OUT_W-3-FRAC){1'b0}}, lvl, {FRAC{1'b0}}});

  always_ff @(posedge clk) begin
    if (rst) begin
      avg_ptr   <= '0;
      elem_en_o <= '0;
      corr_o    <= '0;
      for (int i = 0; i < N_EL; i++) tbl[i] <= '0;
    end else begin
      elem_en_o <= en_nxt;
      corr_o    <= scaled - err_sum;
      if (tbl_we_i) tbl[tbl_addr_i] <= signed'(tbl_data_i);
      if (mode_i == M_AVG) avg_ptr <= avg_ptr + lvl[1:0];
    end
  end
endmodule

module dac_elem_rotator_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] level_i,
  input logic [1:0] mode_i,
  input logic [1:0] ext_ptr_i,
  input logic [3:0] elem_en_o
);
  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> elem_en_o == 4'd0); // R1
  AST_EN_COUNT: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> $countones(elem_en_o) == (($past(level_i) > 3'd4) ? 4 : int'($past(level_i)))); // R2
  AST_CONTIG_RUN: assert property (@(posedge clk) disable iff (rst) $countones(elem_en_o & ~{elem_en_o[2:0], elem_en_o[3]}) <= 1); // R3
  AST_CAL_START: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(mode_i) == 2'b10 && $past(level_i) != 3'd0) |-> elem_en_o[$past(ext_ptr_i)]); // R5
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && ($past(mode_i) == 2'b00 || $past(mode_i) == 2'b11) && $past(level_i) != 3'd0) |-> elem_en_o[0]); // R6
endmodule

bind dac_elem_rotator dac_elem_rotator_chk chk (
  .clk(clk), .rst(rst), .level_i(level_i), .mode_i(mode_i),
  .ext_ptr_i(ext_ptr_i), .elem_en_o(elem_en_o)
);

// File: tb/tb_dac_elem_rotator.sv
`timescale 1ns/1ps
module tb_dac_elem_rotator;
  localparam int CORR_W = 8;
  localparam int FRAC   = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        level_i = '0;
  logic [1:0]        mode_i = '0, ext_ptr_i = '0, tbl_addr_i = '0;
  logic              tbl_we_i = 1'b0;
  logic [CORR_W-1:0] tbl_data_i = '0;
  logic [3:0]        elem_en_o;
  logic signed [CORR_W+2:0] corr_o;

  dac_elem_rotator #(.CORR_W(CORR_W), .FRAC(FRAC)) dut (.*);

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0;
  int ref_ptr = 0;
  int ref_tbl [4] = '{0, 0, 0, 0};
  logic [3:0] exp_en;
  int  exp_corr;
  bit  exp_ok = 0;
  string exp_tag;

  task automatic chk(input string tag);
    n_run++;
    if (elem_en_o !== exp_en) begin
      n_fail++;
      $display("FAIL %s cyc=%0d elem_en act=%b exp=%b", tag, cyc, elem_en_o, exp_en);
    end
    n_run++;
    if (int'(corr_o) != exp_corr) begin
      n_fail++;
      $display("FAIL %s/R7 cyc=%0d corr act=%0d exp=%0d", tag, cyc, int'(corr_o), exp_corr);
    end
  endtask

  // drive one sample at negedge, compute expectation for the next negedge (R9)
  task automatic step(input bit r, input int lv, input int md, input int ep,
                      input bit we, input int wa, input int wd);
    int l, p, s;
    @(negedge clk);
    cyc++;
    if (exp_ok) chk(exp_tag);
    rst = r; level_i = 3'(lv); mode_i = 2'(md); ext_ptr_i = 2'(ep);
    tbl_we_i = we; tbl_addr_i = 2'(wa); tbl_data_i = 8'(wd);
    exp_ok = 1;
    if (r) begin
      exp_en = 0; exp_corr = 0; ref_ptr = 0; ref_tbl = '{0, 0, 0, 0};
      exp_tag = "R1";
      return;
    end
    l = (lv > 4) ? 4 : lv;
    p = (md == 1) ? ref_ptr : (md == 2) ? ep : 0;
    exp_tag = (md == 1) ? "R4/R3" : (md == 2) ? "R5/R3" : "R6/R2";
    if (we) exp_tag = {exp_tag, "/R8"};
    exp_en = 0; s = 0;
    for (int k = 0; k < l; k++) begin
      exp_en[(p + k) % 4] = 1'b1;
      s += ref_tbl[(p + k) % 4];
    end
    exp_corr = l * (1 << FRAC) - s;
    if (we) ref_tbl[wa] = (wd > 127) ? wd - 256 : wd;
    if (md == 1) ref_ptr = (ref_ptr + l) % 4;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);                // R1: cleared outputs after reset
    // load table: 5, -3, 12, -20
    step(0, 2, 0, 0, 1, 0, 5);
    step(0, 2, 0, 0, 1, 1, 253);
    step(0, 4, 0, 0, 1, 2, 12);
    step(0, 4, 0, 0, 1, 3, 236);
    // R2/R6: hold mode over all codes, both encodings
    for (int lv = 0; lv < 8; lv++) step(0, lv, 0, 0, 0, 0, 0);
    for (int lv = 0; lv < 8; lv++) step(0, lv, 3, 2, 0, 0, 0);
    // R5/R3: every pointer against every level
    for (int p = 0; p < 4; p++)
      for (int lv = 0; lv < 6; lv++) step(0, lv, 2, p, 0, 0, 0);
    // R4: averaging run from reset state
    for (int i = 0; i < 300; i++) step(0, $urandom_range(0, 7), 1, 0, 0, 0, 0);
    // R8: write to entry read in the same sample
    step(0, 4, 0, 0, 1, 0, 100);
    step(0, 4, 0, 0, 0, 0, 0);
    // mixed modes, random writes (R5/R6 pointer retention, R8 ordering)
    for (int i = 0; i < 2000; i++)
      step(0, $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 3) == 0, $urandom_range(0, 3), $urandom_range(0, 255));
    // R1: reset mid-run clears table and pointer
    step(1, 3, 1, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) step(0, $urandom_range(0, 7), 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule